// File: doc/BRIEF.md
# Selectable-Order Job Queue

This block is a hardware job queue whose removal order is picked when it is initialised: oldest-first or newest-first. Each entry carries a job identifier and an information word. The maximum length is also set at initialisation and is bounded by a storage-depth parameter. A single request port accepts one of five operations per cycle: initialise, add, remove, full query and examine. Every request returns a small status code, together with data where the operation produces any.

The queue keeps its own statistics, measured in clock cycles of a free-running counter. It stamps every entry with that counter when the entry is added. A removal reports how long the entry waited. The examine operation reports the following:
- the current length;
- the peak length since initialisation;
- the shortest wait seen at removal;
- the age of the oldest entry still queued;
- the average wait over all removals.

Each request is decoded in the cycle it is presented, and the response is registered. The response is therefore valid exactly one cycle after the request.

Top module: `job_queue`

## Requirements
- R1: Initialise (op 0) takes an order code on `req_code_i`: 1 selects oldest-first, 2 selects newest-first. Any other order code returns status 4 and leaves the previous queue state unchanged, defined or undefined. The order code is checked before the length.
- R2: Initialise reads `req_len_i` as a two's-complement length. A value of zero or less, or a value above DEPTH, returns status 5 and leaves the state unchanged. A length from 1 to DEPTH returns status 0.
- R3: Before any successful initialise, every operation other than initialise returns status 2.
- R4: Add (op 1) stores the job and returns status 0 when the entry count is below the configured length. When the count equals the length, add returns status 1 and the contents are left unchanged.
- R5: Remove (op 2) returns status 0 and the removed entry's identifier and information word. In oldest-first order it removes the oldest entry; in newest-first order it removes the newest. `rsp_data_o` carries the entry's wait: the cycle of the remove request minus the cycle of its add request. Removing from an empty queue returns status 3.
- R6: Full query (op 3) returns status 0, with `rsp_data_o` = 1 when the entry count equals the configured length and 0 otherwise.
- R7: Examine (op 4) with code 1 returns the current entry count. Code 3 returns the largest count reached since the last successful initialise.
- R8: Examine code 4 returns the shortest wait among removed jobs. Code 6 returns the total wait of removed jobs divided by the number of removals, rounded down. Both return 0 when there have been no removals.
- R9: Examine code 5 returns the wait so far of the oldest entry still queued, counted up to the examine request cycle. It returns 0 when the queue is empty.
- R10: Once the queue is defined, an examine code other than 1, 3, 4, 5 or 6, or an op code of 5 to 7, returns status 6.
- R11: `rsp_valid_o` is high in exactly the cycle after each cycle with `req_valid_i` high. It stays low after idle cycles.
- R12: A successful initialise empties the queue and clears the peak length, the shortest wait, the wait total and the removal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | 0 initialise, 1 add, 2 remove, 3 full query, 4 examine |
| req_code_i | input | 3 | Order code for initialise, statistic code for examine |
| req_len_i | input | LEN_W | Signed maximum length for initialise |
| req_id_i | input | ID_W | Job identifier for add |
| req_info_i | input | INFO_W | Information word for add |
| rsp_valid_o | output | 1 | Response valid |
| rsp_status_o | output | 3 | 0 ok, 1 full, 2 undefined, 3 empty, 4 bad order, 5 bad length, 6 bad code |
| rsp_data_o | output | DATA_W | Wait, flag or statistic |
| rsp_id_o | output | ID_W | Identifier of the removed job, else 0 |
| rsp_info_o | output | INFO_W | Information word of the removed job, else 0 |

## Verification
The assertions assume that `req_valid_i` and `req_op_i` are held low while reset is active. This lets the one-cycle response relation and the op-dependent status rules hold from the first edge. The stimulus drives every input on the falling edge and keeps the request lines at zero through reset. Wait gaps are kept far below the timestamp range, so the modular cycle difference always equals the true wait.

// File: rtl/jq_pkg.sv
package jq_pkg;
  localparam logic [2:0] OP_INIT   = 3'd0;
  localparam logic [2:0] OP_ADD    = 3'd1;
  localparam logic [2:0] OP_REMOVE = 3'd2;
  localparam logic [2:0] OP_FULL   = 3'd3;
  localparam logic [2:0] OP_EXAM   = 3'd4;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_FULL    = 3'd1;
  localparam logic [2:0] ST_UNDEF   = 3'd2;
  localparam logic [2:0] ST_EMPTY   = 3'd3;
  localparam logic [2:0] ST_BADORD  = 3'd4;
  localparam logic [2:0] ST_BADLEN  = 3'd5;
  localparam logic [2:0] ST_BADCODE = 3'd6;

  localparam logic [2:0] ORD_OLDEST = 3'd1;
  localparam logic [2:0] ORD_NEWEST = 3'd2;

  localparam logic [2:0] EX_LEN  = 3'd1;
  localparam logic [2:0] EX_PEAK = 3'd3;
  localparam logic [2:0] EX_MINW = 3'd4;
  localparam logic [2:0] EX_OLDW = 3'd5;
  localparam logic [2:0] EX_AVGW = 3'd6;
endpackage

// File: rtl/jq_store.sv
module jq_store #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 8,
  parameter int INFO_W = 16,
  parameter int TS_W   = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           newest_i,
  input  logic                           push_i,
  input  logic                           pop_i,
  input  logic [ID_W-1:0]                push_id_i,
  input  logic [INFO_W-1:0]              push_info_i,
  input  logic [TS_W-1:0]                push_ts_i,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic [ID_W-1:0]                out_id_o,
  output logic [INFO_W-1:0]              out_info_o,
  output logic [TS_W-1:0]                out_ts_o,
  output logic [TS_W-1:0]                old_ts_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int ENT_W = ID_W + INFO_W + TS_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [PTR_W:0]   head_x, cnt_x;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W:0] v);
    if (v >= (PTR_W+1)'(DEPTH)) return PTR_W'(v - (PTR_W+1)'(DEPTH));
    return v[PTR_W-1:0];
  endfunction

  assign head_x = {1'b0, head_q};
  assign cnt_x  = (PTR_W+1)'(count_q);
  assign wr_idx = wrap(head_x + cnt_x);
  // oldest always sits at head in both orders; newest-first reads the top
  assign rd_idx = (newest_i && count_q != '0) ? wrap(head_x + cnt_x - 1'b1) : head_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_idx] <= {push_id_i, push_info_i, push_ts_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      head_q  <= '0;
      count_q <= '0;
    end else if (push_i) begin
      count_q <= count_q + 1'b1;
    end else if (pop_i) begin
      count_q <= count_q - 1'b1;
      if (!newest_i) head_q <= wrap(head_x + 1'b1);
    end
  end

  assign count_o = count_q;
  assign {out_id_o, out_info_o, out_ts_o} = mem_q[rd_idx];
  assign old_ts_o = mem_q[head_q][TS_W-1:0];
endmodule

// File: rtl/jq_stats.sv
module jq_stats #(
  parameter int TS_W  = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [TS_W-1:0]  wait_i,
  output logic [TS_W-1:0]  now_o,
  output logic [CNT_W-1:0] peak_o,
  output logic [TS_W-1:0]  min_o,
  output logic [SUM_W-1:0] avg_o
);
  logic [TS_W-1:0]  now_q, min_q;
  logic [CNT_W-1:0] peak_q;
  logic [SUM_W-1:0] sum_q, nrem_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = count_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= '0;
      min_q  <= '0;
      sum_q  <= '0;
      nrem_q <= '0;
    end else if (clear_i) begin
      peak_q <= '0;
      min_q  <= '0;
      sum_q  <= '0;
      nrem_q <= '0;
    end else begin
      if (push_i && cnt_next > peak_q) peak_q <= cnt_next;
      if (pop_i) begin
        sum_q  <= sum_q + SUM_W'(wait_i);
        nrem_q <= nrem_q + 1'b1;
        if (nrem_q == '0 || wait_i < min_q) min_q <= wait_i;
      end
    end
  end

  assign now_o  = now_q;
  assign peak_o = peak_q;
  assign min_o  = min_q;
  assign avg_o  = (nrem_q == '0) ? '0 : sum_q / nrem_q;
endmodule

// File: rtl/job_queue.sv
module job_queue
  import jq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 8,
  parameter int INFO_W = 16,
  parameter int LEN_W  = 8,
  parameter int TS_W   = 16,
  parameter int SUM_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [2:0]        req_code_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [INFO_W-1:0] req_info_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_status_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [INFO_W-1:0] rsp_info_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic              defined_q, newest_q;
  logic [CNT_W-1:0]  len_q, count, peak;
  logic [TS_W-1:0]   now, min_w, out_ts, old_ts, wait_out, wait_old;
  logic [SUM_W-1:0]  avg_w;
  logic [ID_W-1:0]   out_id;
  logic [INFO_W-1:0] out_info;
  logic              push, pop, clear, len_ok, ord_ok;
  logic [2:0]        st_d;
  logic [DATA_W-1:0] data_d;

  jq_store #(.DEPTH(DEPTH), .ID_W(ID_W), .INFO_W(INFO_W), .TS_W(TS_W)) u_store (
    .clk_i, .rst_ni, .clear_i(clear), .newest_i(newest_q), .push_i(push), .pop_i(pop),
    .push_id_i(req_id_i), .push_info_i(req_info_i), .push_ts_i(now),
    .count_o(count), .out_id_o(out_id), .out_info_o(out_info),
    .out_ts_o(out_ts), .old_ts_o(old_ts)
  );

  jq_stats #(.TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni, .clear_i(clear), .push_i(push), .pop_i(pop),
    .count_i(count), .wait_i(wait_out),
    .now_o(now), .peak_o(peak), .min_o(min_w), .avg_o(avg_w)
  );

  assign wait_out = now - out_ts;
  assign wait_old = now - old_ts;
  assign ord_ok   = (req_code_i == ORD_OLDEST) || (req_code_i == ORD_NEWEST);
  assign len_ok   = !req_len_i[LEN_W-1] && (req_len_i != '0) &&
                    (req_len_i <= LEN_W'(DEPTH));

  always_comb begin
    st_d   = ST_OK;
    data_d = '0;
    push   = 1'b0;
    pop    = 1'b0;
    clear  = 1'b0;
    if (req_valid_i) begin
      if (req_op_i == OP_INIT) begin
        if (!ord_ok)      st_d  = ST_BADORD;
        else if (!len_ok) st_d  = ST_BADLEN;
        else              clear = 1'b1;
      end else if (!defined_q) begin
        st_d = ST_UNDEF;
      end else begin
        unique case (req_op_i)
          OP_ADD: begin
            if (count == len_q) st_d = ST_FULL;
            else                push = 1'b1;
          end
          OP_REMOVE: begin
            if (count == '0) st_d = ST_EMPTY;
            else begin
              pop    = 1'b1;
              data_d = DATA_W'(wait_out);
            end
          end
          OP_FULL: data_d = DATA_W'(count == len_q);
          OP_EXAM: begin
            unique case (req_code_i)
              EX_LEN:  data_d = DATA_W'(count);
              EX_PEAK: data_d = DATA_W'(peak);
              EX_MINW: data_d = DATA_W'(min_w);
              EX_OLDW: data_d = (count == '0) ? '0 : DATA_W'(wait_old);
              EX_AVGW: data_d = DATA_W'(avg_w);
              default: st_d   = ST_BADCODE;
            endcase
          end
          default: st_d = ST_BADCODE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      defined_q <= 1'b0;
      newest_q  <= 1'b0;
      len_q     <= '0;
    end else if (clear) begin
      defined_q <= 1'b1;
      newest_q  <= (req_code_i == ORD_NEWEST);
      len_q     <= CNT_W'(req_len_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_OK;
      rsp_data_o   <= '0;
      rsp_id_o     <= '0;
      rsp_info_o   <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_status_o <= st_d;
      rsp_data_o   <= data_d;
      rsp_id_o     <= pop ? out_id : '0;
      rsp_info_o   <= pop ? out_info : '0;
    end
  end
endmodule

// File: rtl/jq_chk.sv
module jq_chk
  import jq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_status_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [CNT_W-1:0]  count_i
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i));

  // R1
  bad_order_from_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_BADORD) |-> $past(req_op_i) == OP_INIT);

  // R2
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  // R4
  full_only_on_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_FULL) |-> ($past(req_op_i) == OP_ADD && $stable(count_i)));

  // R4
  add_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_OK && $past(req_op_i) == OP_ADD)
      |-> count_i == $past(count_i) + 1'b1);

  // R5
  remove_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_OK && $past(req_op_i) == OP_REMOVE)
      |-> count_i == $past(count_i) - 1'b1);

  // R5
  empty_only_on_remove_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_EMPTY) |-> ($past(req_op_i) == OP_REMOVE && count_i == '0));

  // R6
  full_flag_binary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_OK && $past(req_op_i) == OP_FULL) |-> rsp_data_o <= 1);
endmodule

bind job_queue jq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_jq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o), .rsp_data_o(rsp_data_o),
  .count_i(count)
);

// File: tb/job_queue_bench.sv
`timescale 1ns/1ps
module job_queue_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0, req_code = '0;
  logic [7:0]  req_len = '0, req_id = '0;
  logic [15:0] req_info = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_data;
  logic [7:0]  rsp_id;
  logic [15:0] rsp_info;

  int total = 0, bad = 0;
  int edges = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  job_queue u_job_queue (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_code_i(req_code), .req_len_i(req_len), .req_id_i(req_id), .req_info_i(req_info),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_data_o(rsp_data),
    .rsp_id_o(rsp_id), .rsp_info_o(rsp_info)
  );

  typedef struct packed { logic [7:0] id; logic [15:0] info; int ts; } ent_t;
  typedef struct packed { logic [2:0] st; logic [31:0] data; logic [7:0] id; logic [15:0] info; } exp_t;

  // model
  bit   m_def = 0, m_new = 0;
  int   m_len = 0, m_peak = 0, m_min = 0, m_sum = 0, m_nrem = 0;
  ent_t m_q[$];

  exp_t  sb_q[$];
  string sb_tag[$];

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int code, input int len, input int id,
                       input int info, input string tag);
    exp_t e;
    ent_t x;
    int   ts;
    ts = edges + 1;
    e = '0;
    if (op == 0) begin
      if (code != 1 && code != 2) e.st = 3'd4;
      else if (len <= 0 || len > DEPTH) e.st = 3'd5;
      else begin
        m_def = 1; m_new = (code == 2); m_len = len;
        m_q.delete(); m_peak = 0; m_min = 0; m_sum = 0; m_nrem = 0;
      end
    end else if (!m_def) e.st = 3'd2;
    else begin
      case (op)
        1: if (m_q.size() == m_len) e.st = 3'd1;
           else begin
             x.id = 8'(id); x.info = 16'(info); x.ts = ts;
             m_q.push_back(x);
             if (m_q.size() > m_peak) m_peak = m_q.size();
           end
        2: if (m_q.size() == 0) e.st = 3'd3;
           else begin
             x = m_new ? m_q.pop_back() : m_q.pop_front();
             e.data = 32'(ts - x.ts); e.id = x.id; e.info = x.info;
             if (m_nrem == 0 || ts - x.ts < m_min) m_min = ts - x.ts;
             m_sum += ts - x.ts; m_nrem++;
           end
        3: e.data = 32'(m_q.size() == m_len);
        4: case (code)
             1: e.data = 32'(m_q.size());
             3: e.data = 32'(m_peak);
             4: e.data = 32'(m_min);
             5: e.data = (m_q.size() == 0) ? 0 : 32'(ts - m_q[0].ts);
             6: e.data = (m_nrem == 0) ? 0 : 32'(m_sum / m_nrem);
             default: e.st = 3'd6;
           endcase
        default: e.st = 3'd6;
      endcase
    end
    sb_q.push_back(e);
    sb_tag.push_back(tag);
    req_valid = 1'b1; req_op = 3'(op); req_code = 3'(code);
    req_len = 8'(len); req_id = 8'(id); req_info = 16'(info);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!rsp_valid, "R11 idle", $sformatf("%0b", rsp_valid), "0");
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) chk(1'b0, "R11 unexpected response", "valid", "none");
      else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        chk(rsp_status == e.st && rsp_data == e.data && rsp_id == e.id && rsp_info == e.info, t,
            $sformatf("st=%0d data=%0d id=%0h info=%0h", rsp_status, rsp_data, rsp_id, rsp_info),
            $sformatf("st=%0d data=%0d id=%0h info=%0h", e.st, e.data, e.id, e.info));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_status == 0, "R11 reset state",
        $sformatf("%0b/%0d", rsp_valid, rsp_status), "0/0");
    rst_n = 1'b1;
    @(negedge clk);

    // undefined queue and rejected initialisation
    issue(1, 0, 0, 8'h11, 16'h1, "R3 add before init");
    issue(4, 1, 0, 0, 0, "R3 examine before init");
    issue(2, 0, 0, 0, 0, "R3 remove before init");
    issue(0, 0, 3, 0, 0, "R1 order code 0");
    issue(0, 3, 3, 0, 0, "R1 order code 3");
    issue(0, 7, 0, 0, 0, "R1 order checked before length");
    issue(0, 1, 0, 0, 0, "R2 length zero");
    issue(0, 1, -1, 0, 0, "R2 negative length");
    issue(0, 1, DEPTH + 1, 0, 0, "R2 length above depth");
    issue(3, 0, 0, 0, 0, "R1 queue still undefined");

    // oldest-first, length 3
    issue(0, 1, 3, 0, 0, "R1 init oldest-first");
    issue(1, 0, 0, 8'hA1, 16'h1001, "R4 add a");
    idle(2);
    issue(1, 0, 0, 8'hA2, 16'h1002, "R4 add b");
    idle(4);
    issue(3, 0, 0, 0, 0, "R6 not full");
    issue(1, 0, 0, 8'hA3, 16'h1003, "R4 add c");
    issue(1, 0, 0, 8'hA4, 16'h1004, "R4 add refused when full");
    issue(3, 0, 0, 0, 0, "R6 full");
    issue(4, 1, 0, 0, 0, "R7 length after refused add");
    issue(4, 5, 0, 0, 0, "R9 oldest wait");
    idle(3);
    issue(2, 0, 0, 0, 0, "R5 oldest-first removes a");
    issue(4, 5, 0, 0, 0, "R9 oldest wait after removal");
    issue(2, 0, 0, 0, 0, "R5 oldest-first removes b");
    idle(1);
    issue(2, 0, 0, 0, 0, "R5 oldest-first removes c");
    issue(2, 0, 0, 0, 0, "R5 remove from empty");
    issue(4, 5, 0, 0, 0, "R9 empty oldest wait");
    issue(4, 3, 0, 0, 0, "R7 peak");
    issue(4, 4, 0, 0, 0, "R8 shortest wait");
    issue(4, 6, 0, 0, 0, "R8 average wait");
    issue(4, 2, 0, 0, 0, "R10 examine code 2");
    issue(4, 7, 0, 0, 0, "R10 examine code 7");
    issue(6, 0, 0, 0, 0, "R10 op code 6");
    issue(0, 5, 2, 0, 0, "R1 bad order keeps queue");
    issue(4, 3, 0, 0, 0, "R1 peak kept after bad order");

    // newest-first, length 4
    issue(0, 2, 4, 0, 0, "R12 init newest-first");
    issue(4, 3, 0, 0, 0, "R12 peak cleared");
    issue(4, 4, 0, 0, 0, "R12 shortest cleared");
    issue(4, 6, 0, 0, 0, "R12 average cleared");
    issue(4, 1, 0, 0, 0, "R12 length cleared");
    for (int i = 0; i < 4; i++) begin
      issue(1, 0, 0, 8'hB0 + i, 16'h2000 + i, "R4 add newest-first");
      idle(i);
    end
    issue(1, 0, 0, 8'hBF, 16'h2FFF, "R4 refused newest-first");
    issue(2, 0, 0, 0, 0, "R5 newest-first removes b3");
    issue(2, 0, 0, 0, 0, "R5 newest-first removes b2");
    issue(1, 0, 0, 8'hC0, 16'h3000, "R4 add after removals");
    idle(2);
    issue(4, 5, 0, 0, 0, "R9 oldest wait newest-first");
    issue(2, 0, 0, 0, 0, "R5 newest-first removes c0");
    issue(2, 0, 0, 0, 0, "R5 newest-first removes b1");
    issue(2, 0, 0, 0, 0, "R5 newest-first removes b0");
    issue(4, 4, 0, 0, 0, "R8 shortest newest-first");
    issue(4, 6, 0, 0, 0, "R8 average newest-first");
    issue(4, 3, 0, 0, 0, "R7 peak newest-first");

    // full depth, oldest-first, pointer wrap
    issue(0, 1, DEPTH, 0, 0, "R2 length equal to depth");
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 5; i++) issue(1, 0, 0, 8'h40 + r * 8 + i, 16'h4000 + r * 16 + i, "R4 wrap add");
      idle(r);
      for (int i = 0; i < 4; i++) issue(2, 0, 0, 0, 0, "R5 wrap remove");
    end
    for (int i = 0; i < 5; i++) issue(1, 0, 0, 8'h70 + i, 16'h7000 + i, "R4 fill to depth");
    issue(1, 0, 0, 8'h7F, 16'h7FFF, "R4 refused at depth");
    issue(3, 0, 0, 0, 0, "R6 full at depth");
    issue(4, 3, 0, 0, 0, "R7 peak at depth");
    for (int i = 0; i < DEPTH; i++) issue(2, 0, 0, 0, 0, "R5 drain");
    issue(4, 6, 0, 0, 0, "R8 average after wrap");
    issue(4, 4, 0, 0, 0, "R8 shortest after wrap");
    idle(2);

    chk(sb_q.size() == 0, "R11 all responses seen", $sformatf("%0d", sb_q.size()), "0");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule